// File: doc/BRIEF.md
# Tree Carry Look-Ahead Adder

This block adds two unsigned words and a carry-in and returns the sum word and a carry-out, with no clock and no stored state. Every bit position first sorts itself into one of three cases: it creates a carry, it passes an incoming carry along, or it blocks one. It does this by forming a generate and a propagate signal from its two operand bits.

A balanced binary tree of merge nodes then joins neighbouring spans into wider spans, each described by one propagate/generate pair, until a single pair covers the whole word. The same nodes send carries back toward the leaves. A node hands its own incoming carry straight to its lower half. Its upper half gets the carry that leaves the lower half, computed from that half's pair. The depth grows with the logarithm of the width and not with the width itself.

The block drops into a datapath wherever a plain `+` with carry-in and carry-out is needed and a known, shallow logic depth matters. It has no handshake at its edge, because nothing flows through it over time: the outputs follow the inputs combinationally.

Top module: `tree_cla_adder`

## Requirements
- R1: For every input combination, `sum_o` equals the low WIDTH bits of `a_i + b_i + carry_i`.
- R2: For every input combination, `carry_o` equals bit WIDTH of `a_i + b_i + carry_i`.
- R3: When every bit position has operand bits that differ, the carry-in crosses the whole word. With carry-in 1 the sum is all zeros and the carry-out is 1 (for example 0xFF + 0x00 + 1 at 8 bits).
- R4: A bit position whose two operand bits are both 1 delivers a carry into the next position whatever its own incoming carry is. Example: 0x80 + 0x80 + 0 gives sum 0x00 and carry-out 1.
- R5: With both operands zero, the sum equals the carry-in and the carry-out is 0. A position where both operand bits are 0 lets no carry through.
- R6: When the whole word propagates and the carry-in is 0, the carry-out is 0 and the sum is all ones (0xF0 + 0x0F + 0 gives 0xFF with carry-out 0).
- R7: WIDTH is a parameter that must be a power of two of at least 2. R1 and R2 hold at WIDTH 2 and WIDTH 16 as well as at the default of 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| carry_o | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach is a carry that has to climb the whole tree and come back down to every leaf. That happens only when every position propagates, so that the root pair's propagate is 1 and its generate is 0, and the answer then depends on the carry-in alone. Directed vectors set up exactly this case with both carry-in values. An exhaustive sweep of all operand and carry-in combinations at 8 bits then covers every mix of generate, propagate and kill spans under every merge node. The 2-bit instance is swept fully. The 16-bit instance is driven with pseudo-random words.

// File: rtl/tcla_pkg.sv
package tcla_pkg;

  // Propagate/generate summary of a span of bit positions
  typedef struct packed {
    logic p;
    logic g;
  } pg_t;

  // Join a lower span with the upper span directly above it
  function automatic pg_t pg_merge(pg_t lo, pg_t hi);
    pg_t r;
    r.p = lo.p & hi.p;
    r.g = hi.g | (lo.g & hi.p);
    return r;
  endfunction

  // Carry leaving a span, given the carry entering it
  function automatic logic carry_across(pg_t span, logic cin);
    return span.g | (cin & span.p);
  endfunction

endpackage

// File: rtl/tcla_bit_cell.sv
module tcla_bit_cell
  import tcla_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output pg_t  pg_o,
  output logic sum_o
);

  always_comb begin
    pg_o.p = a_i ^ b_i;
    pg_o.g = a_i & b_i;
  end

  assign sum_o = pg_o.p ^ c_i;

  // A position cannot both create and pass a carry
  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      AST_BIT_PG_EXCL: assert (!(pg_o.p && pg_o.g)); // R4
    end
  end

endmodule

// File: rtl/tcla_merge_node.sv
module tcla_merge_node
  import tcla_pkg::*;
(
  input  pg_t  lo_i,
  input  pg_t  hi_i,
  input  logic c_i,
  output pg_t  grp_o,
  output logic c_lo_o,
  output logic c_hi_o
);

  assign grp_o  = pg_merge(lo_i, hi_i);
  assign c_lo_o = c_i;
  assign c_hi_o = carry_across(lo_i, c_i);

  always_comb begin
    if (!$isunknown({lo_i, hi_i, c_i})) begin
      AST_SPAN_PG_EXCL: assert (!(grp_o.p && grp_o.g)); // R2
      AST_PASS_REACHES_UPPER: assert (!grp_o.p || (c_hi_o == c_i)); // R3
      AST_UPPER_GEN_KEPT: assert (!hi_i.g || grp_o.g); // R4
    end
  end

endmodule

// File: rtl/tcla_carry_tree.sv
module tcla_carry_tree
  import tcla_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  pg_t  [WIDTH-1:0] bit_pg_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] bit_c_o,
  output pg_t              root_o
);

  localparam int LEVELS = $clog2(WIDTH);

  for (genvar lvl = 1; lvl <= LEVELS; lvl++) begin : g_lvl
    localparam int N = WIDTH >> lvl;

    pg_t  [N-1:0]   grp;
    pg_t  [2*N-1:0] kids;
    logic [N-1:0]   cin_grp;
    logic [2*N-1:0] c_kid;

    if (lvl == 1) begin : g_leaf_src
      assign kids = bit_pg_i;
    end else begin : g_node_src
      assign kids = g_lvl[lvl-1].grp;
    end

    if (lvl == LEVELS) begin : g_root_cin
      assign cin_grp = c_i;
    end else begin : g_inner_cin
      assign cin_grp = g_lvl[lvl+1].c_kid;
    end

    for (genvar j = 0; j < N; j++) begin : g_node
      tcla_merge_node u_node (
        .lo_i  (kids[2*j]),
        .hi_i  (kids[2*j+1]),
        .c_i   (cin_grp[j]),
        .grp_o (grp[j]),
        .c_lo_o(c_kid[2*j]),
        .c_hi_o(c_kid[2*j+1])
      );
    end
  end

  assign bit_c_o = g_lvl[1].c_kid;
  assign root_o  = g_lvl[LEVELS].grp[0];

  always_comb begin
    if (!$isunknown({bit_pg_i, c_i})) begin
      AST_LSB_CARRY_IS_CIN: assert (bit_c_o[0] == c_i); // R5
    end
  end

endmodule

// File: rtl/tree_cla_adder.sv
module tree_cla_adder
  import tcla_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);

  localparam int EXT = WIDTH + 1;

  pg_t  [WIDTH-1:0] bit_pg;
  logic [WIDTH-1:0] bit_c;
  pg_t              root_pg;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    tcla_bit_cell u_cell (
      .a_i  (a_i[i]),
      .b_i  (b_i[i]),
      .c_i  (bit_c[i]),
      .pg_o (bit_pg[i]),
      .sum_o(sum_o[i])
    );
  end

  tcla_carry_tree #(.WIDTH(WIDTH)) u_tree (
    .bit_pg_i(bit_pg),
    .c_i     (carry_i),
    .bit_c_o (bit_c),
    .root_o  (root_pg)
  );

  assign carry_o = carry_across(root_pg, carry_i);

  logic [EXT-1:0] ref_total;
  assign ref_total = EXT'(a_i) + EXT'(b_i) + EXT'(carry_i);

  always_comb begin
    if (!$isunknown({a_i, b_i, carry_i})) begin
      AST_SUM_MATCH: assert (sum_o == ref_total[WIDTH-1:0]); // R1
      AST_COUT_MATCH: assert (carry_o == ref_total[WIDTH]); // R2
      AST_ALL_PASS_COUT: assert (!(&(a_i ^ b_i)) || (carry_o == carry_i)); // R6
    end
  end

endmodule

// File: tb/test_tree_cla_adder.sv
module test_tree_cla_adder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  logic rst_n = 1'b0;

  logic [7:0]  a8 = '0, b8 = '0, s8;
  logic        c8 = 1'b0, co8;
  logic [1:0]  a2 = '0, b2 = '0, s2;
  logic        c2 = 1'b0, co2;
  logic [15:0] a16 = '0, b16 = '0, s16;
  logic        c16 = 1'b0, co16;

  tree_cla_adder #(.WIDTH(8)) i_tree_cla_adder (
    .a_i(a8), .b_i(b8), .carry_i(c8), .sum_o(s8), .carry_o(co8));
  tree_cla_adder #(.WIDTH(2)) i_tree_cla_adder_w2 (
    .a_i(a2), .b_i(b2), .carry_i(c2), .sum_o(s2), .carry_o(co2));
  tree_cla_adder #(.WIDTH(16)) i_tree_cla_adder_w16 (
    .a_i(a16), .b_i(b16), .carry_i(c16), .sum_o(s16), .carry_o(co16));

  typedef struct {
    int          req;
    logic [8:0]  e8;
    bit          use2;
    logic [2:0]  e2;
    bit          use16;
    logic [16:0] e16;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit timeout = 1'b0;
  logic [31:0] rng = 32'h1234_5679;

  task automatic drive(input int req, input logic [7:0] a, input logic [7:0] b, input logic c,
                       input bit u2, input logic [1:0] x2, input logic [1:0] y2, input logic z2,
                       input bit u16, input logic [15:0] x16, input logic [15:0] y16, input logic z16);
    exp_t e;
    @(posedge clk);
    a8 = a; b8 = b; c8 = c;
    e.req = req;
    e.e8 = 9'(a) + 9'(b) + 9'(c);
    e.use2 = u2;
    e.e2 = 3'(x2) + 3'(y2) + 3'(z2);
    e.use16 = u16;
    e.e16 = 17'(x16) + 17'(y16) + 17'(z16);
    if (u2) begin a2 = x2; b2 = y2; c2 = z2; end
    if (u16) begin a16 = x16; b16 = y16; c16 = z16; end
    sb.push_back(e);
  endtask

  // Monitor: compares half a period after each drive
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if ({co8, s8} !== e.e8) begin
          fails++;
          $display("FAIL R%0d: width 8 got %h expected %h", e.req, {co8, s8}, e.e8);
        end
        if (e.use2) begin
          checks++;
          if ({co2, s2} !== e.e2) begin
            fails++;
            $display("FAIL R7: width 2 got %h expected %h", {co2, s2}, e.e2);
          end
        end
        if (e.use16) begin
          checks++;
          if ({co16, s16} !== e.e16) begin
            fails++;
            $display("FAIL R7: width 16 got %h expected %h", {co16, s16}, e.e16);
          end
        end
      end
    end
  end

  // Driver
  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive(5, 8'h00, 8'h00, 1'b0, 0, '0, '0, 1'b0, 0, '0, '0, 1'b0); // R5 idle state
    drive(5, 8'h00, 8'h00, 1'b1, 0, '0, '0, 1'b0, 0, '0, '0, 1'b0); // R5 sum = cin
    drive(3, 8'hFF, 8'h00, 1'b1, 1, 2'b11, 2'b00, 1'b1, 1, 16'hFFFF, 16'h0000, 1'b1); // R3 full pass
    drive(3, 8'h55, 8'hAA, 1'b1, 1, 2'b01, 2'b10, 1'b1, 1, 16'h5A5A, 16'hA5A5, 1'b1); // R3
    drive(6, 8'hF0, 8'h0F, 1'b0, 1, 2'b10, 2'b01, 1'b0, 1, 16'hFF00, 16'h00FF, 1'b0); // R6
    drive(4, 8'h80, 8'h80, 1'b0, 0, '0, '0, 1'b0, 1, 16'h8000, 16'h8000, 1'b0); // R4 top generate
    drive(4, 8'h01, 8'h01, 1'b1, 0, '0, '0, 1'b0, 0, '0, '0, 1'b0); // R4
    for (int k = 0; k < (1 << 17); k++) begin
      logic [16:0] kv;
      logic [31:0] r1, r2;
      kv = 17'(k);
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      r1 = rng;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      r2 = rng;
      // R1 and R2 exhaustive at 8 bits; R7 at widths 2 and 16
      drive(1, kv[7:0], kv[15:8], kv[16],
            k < 32, kv[1:0], kv[3:2], kv[4],
            k < 4096, r1[15:0], r2[15:0], r2[16]);
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  // Watchdog and summary
  initial begin
    fork
      wait (done);
      begin repeat (WATCHDOG) @(posedge clk); timeout = 1'b1; end
    join_any
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run incomplete, got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule